// File: doc/BRIEF.md
# KNX Twisted-Pair Bit Codec

This block sits in the host logic beside a twisted-pair line transceiver and handles the line at bit level. On the send side it takes one bit at a time from a valid/ready stream and drives the transceiver's transmit pin. A 0 becomes a high pulse of 35 µs at the start of a 104 µs cell. A 1 leaves the pin low for the whole cell. The transceiver does not time these pulses, so their length is set entirely by this coder. The pin is high when the bus voltage is pulled down, so its sense is inverted against the bus.

On the receive side the block brings the transceiver's receive pin through a two-stage synchronizer. A high run counts as a 0 pulse only when it lasts at least 15 µs. The first such pulse starts the cell framing, with the cell aligned to that pulse's rising edge. After that the decoder reports one bit at the end of every cell: a 0 if a qualifying pulse fell in the cell, and a 1 otherwise. The equalization tail after a pulse stays inside the same cell. After a run of 1 cells of a set length, the decoder stops framing and waits for the next pulse.

While a 1 is being sent, a qualifying pulse on the receive side means another node is pulling the line. The block reports this as a one-cycle collision flag. All timings are whole multiples of a clock-ticks-per-microsecond parameter.

Top module: `tp_codec`

## Requirements
- R1: A bit cell lasts CELL = 104·TPU clock cycles, where TPU is ticks per microsecond. tx_ready is high only while the coder is idle or in the last cycle of a cell, so accepted bits start exactly CELL cycles apart when they are sent back to back.
- R2: An accepted 0 drives txd high from the cycle after acceptance for exactly PULSE = 35·TPU cycles, then low for the rest of the cell.
- R3: An accepted 1 keeps txd low for its whole cell.
- R4: rxd is sampled through two flip-flops. A high run of at least MINW = 15·TPU cycles is a qualifying 0 pulse. A shorter high run is ignored.
- R5: While not framed, the decoder emits no rx_valid. Framing begins only on a qualifying pulse, and the cell is aligned to that pulse's synchronized rising edge.
- R6: While framed, each cell yields exactly one single-cycle rx_valid at its end. rx_bit is 0 if a qualifying pulse occurred in the cell and 1 if none did.
- R7: After END_ONES consecutive 1 cells have been reported, the decoder leaves framing and emits nothing more until the next qualifying pulse.
- R8: tx_collide pulses for one cycle, one cycle after a qualifying pulse that is detected while the coder is sending a 1. It stays low when the received pulses are the coder's own 0s.
- R9: After reset txd, rx_valid and tx_collide are low and tx_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | A bit to send is offered |
| tx_bit | input | 1 | Bit value to send |
| tx_ready | output | 1 | Coder takes the offered bit on this edge |
| txd | output | 1 | Transceiver transmit pin, high = active pulse |
| rxd | input | 1 | Transceiver receive pin, high = pulse detected |
| rx_valid | output | 1 | One-cycle strobe: a received bit is on rx_bit |
| rx_bit | output | 1 | Received bit value |
| tx_collide | output | 1 | One-cycle flag: a 0 was received while a 1 was sent |

## Verification
A cell counter that is wrong in the coder shows at once on txd as a pulse of the wrong width, or as a change in the spacing between the rising edges of back-to-back 0 bits. A fault in the decoder's high-run counter or framing shows within one cell. A short glitch can then produce an rx_valid, a 0 at the exact minimum width can be lost, or the frame can end after the wrong number of trailing 1 cells. A wrong collision condition shows as a flag during ordinary loopback of 0s, or as a missing flag when an outside pulse lands in a 1 cell.

// File: rtl/tp_codec_pkg.sv
package tp_codec_pkg;
  // Convert a duration in microseconds to clock ticks.
  function automatic int us_ticks(input int us, input int tpu);
    return us * tpu;
  endfunction

  // Width of a counter able to hold values 0..n-1.
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tp_tx_coder.sv
module tp_tx_coder #(
  parameter int CELL_T  = 208,
  parameter int PULSE_T = 70,
  parameter int CW      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic accept,
  output logic busy,
  output logic cur_bit,
  output logic txd
);
  logic          busy_q;
  logic          bit_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last     = busy_q && (cnt_q == CW'(CELL_T - 1));
  assign in_ready = !busy_q || last;
  assign accept   = in_valid && in_ready;
  assign busy     = busy_q;
  assign cur_bit  = bit_q;
  assign txd      = busy_q && !bit_q && (cnt_q < CW'(PULSE_T));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      bit_q  <= in_bit;
      cnt_q  <= '0;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tp_rx_decoder.sv
module tp_rx_decoder #(
  parameter int CELL_T   = 208,
  parameter int MINW_T   = 30,
  parameter int END_ONES = 10,
  parameter int CW       = 8,
  parameter int HW       = 5,
  parameter int OW       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic rx_valid,
  output logic rx_bit,
  output logic qual,
  output logic framed,
  output logic cell_end
);
  logic          s1_q, s2_q;
  logic [HW-1:0] hi_q;
  logic          framed_q, got0_q, valid_q, bit_q;
  logic [CW-1:0] pos_q;
  logic [OW-1:0] ones_q;
  logic          zero_cell;

  assign qual      = s2_q && (hi_q == HW'(MINW_T - 1));
  assign cell_end  = framed_q && (pos_q == CW'(CELL_T - 1));
  assign zero_cell = got0_q || qual;
  assign framed    = framed_q;
  assign rx_valid  = valid_q;
  assign rx_bit    = bit_q;

  // Synchronizer and saturating high-run counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      hi_q <= '0;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
      if (!s2_q)                     hi_q <= '0;
      else if (hi_q != HW'(MINW_T))  hi_q <= hi_q + 1'b1;
    end
  end

  // Cell framing and bit decision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      framed_q <= 1'b0;
      got0_q   <= 1'b0;
      valid_q  <= 1'b0;
      bit_q    <= 1'b1;
      pos_q    <= '0;
      ones_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (!framed_q) begin
        if (qual) begin
          framed_q <= 1'b1;
          pos_q    <= CW'(MINW_T);
          got0_q   <= 1'b1;
          ones_q   <= '0;
        end
      end else if (cell_end) begin
        valid_q <= 1'b1;
        bit_q   <= !zero_cell;
        pos_q   <= '0;
        got0_q  <= 1'b0;
        if (zero_cell)                           ones_q   <= '0;
        else if (ones_q == OW'(END_ONES - 1))    framed_q <= 1'b0;
        else                                     ones_q   <= ones_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
        if (qual) got0_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tp_codec.sv
module tp_codec #(
  parameter int TICKS_PER_US = 16,
  parameter int END_ONES     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic txd,
  input  logic rxd,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_collide
);
  import tp_codec_pkg::*;

  localparam int CELL_T  = us_ticks(104, TICKS_PER_US);
  localparam int PULSE_T = us_ticks(35, TICKS_PER_US);
  localparam int MINW_T  = us_ticks(15, TICKS_PER_US);
  localparam int CW      = cnt_w(CELL_T);
  localparam int HW      = cnt_w(MINW_T + 1);
  localparam int OW      = cnt_w(END_ONES);

  // Named internal events, observed by the bound checker.
  logic tx_accept, tx_busy, tx_cur_bit;
  logic rx_qual, rx_framed, rx_cell_end;
  logic collide_q;

  tp_tx_coder #(.CELL_T(CELL_T), .PULSE_T(PULSE_T), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_bit(tx_bit),
    .in_ready(tx_ready), .accept(tx_accept), .busy(tx_busy),
    .cur_bit(tx_cur_bit), .txd(txd)
  );

  tp_rx_decoder #(.CELL_T(CELL_T), .MINW_T(MINW_T), .END_ONES(END_ONES),
                  .CW(CW), .HW(HW), .OW(OW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .qual(rx_qual), .framed(rx_framed),
    .cell_end(rx_cell_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) collide_q <= 1'b0;
    else        collide_q <= rx_qual && tx_busy && tx_cur_bit;
  end
  assign tx_collide = collide_q;
endmodule

// File: rtl/tp_codec_chk.sv
module tp_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic rxd,
  input logic txd,
  input logic tx_ready,
  input logic tx_accept,
  input logic tx_bit,
  input logic rx_valid,
  input logic rx_qual,
  input logic rx_framed,
  input logic tx_collide
);
  a_r1_ready_low_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    txd |-> !tx_ready);
  a_r2_zero_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept && !tx_bit |=> txd);
  a_r3_one_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept && tx_bit |=> !txd);
  a_r4_qual_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    rx_qual |-> $past(rxd, 2));
  a_r5_frame_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_framed) |-> $past(rx_qual));
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_collide_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_collide |-> $past(rx_qual));
endmodule

bind tp_codec tp_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .tx_ready(tx_ready),
  .tx_accept(tx_accept), .tx_bit(tx_bit), .rx_valid(rx_valid),
  .rx_qual(rx_qual), .rx_framed(rx_framed), .tx_collide(tx_collide)
);

// File: tb/tp_codec_bench.sv
module tp_codec_bench;
  localparam int TPU  = 2;
  localparam int ENDN = 10;

  function automatic int ticks(input int us);
    return us * TPU;
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid = 1'b0, tx_bit = 1'b0;
  logic loop_en = 1'b0, ext = 1'b0;
  logic tx_ready, txd, rx_valid, rx_bit, tx_collide;
  logic rxd;
  assign rxd = (loop_en & txd) | ext;

  always #10 clk = ~clk;

  tp_codec #(.TICKS_PER_US(TPU), .END_ONES(ENDN)) u_tp_codec (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_bit(tx_bit),
    .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .tx_collide(tx_collide)
  );

  int errors = 0, checks = 0;
  int cyc = 0, run = 0, npulse = 0, ncoll = 0, rx_n = 0, nrise = 0;
  logic prev_txd = 1'b0;
  logic rxq [0:511];
  int   rise [0:15];
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitors, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (txd) run++;
    else if (run > 0) begin
      chk(run == ticks(35), "R2 pulse width", run, ticks(35));
      npulse++;
      run = 0;
    end
    if (txd && !prev_txd && nrise < 16) begin rise[nrise] = cyc; nrise++; end
    prev_txd = txd;
    if (tx_collide) ncoll++;
    if (rx_valid && rx_n < 512) begin rxq[rx_n] = rx_bit; rx_n++; end
  end

  task automatic send_bit(input logic b);
    tx_bit = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic ext_pulse(input int len);
    @(negedge clk); ext = 1'b1;
    repeat (len) @(negedge clk);
    ext = 1'b0;
  endtask

  task automatic wait_cells(input int n);
    repeat (n * ticks(104)) @(negedge clk);
  endtask

  logic sent [0:63];

  initial begin
    int nbits, ones, trail;
    void'($urandom(32'h1A2B));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(txd == 1'b0, "R9 txd", txd, 0);
    chk(tx_ready == 1'b1, "R9 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
    chk(tx_collide == 1'b0, "R9 tx_collide", tx_collide, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Loopback of random bits (R2 R3 R5 R6 R7 R8)
    loop_en = 1'b1; nbits = 40; ones = 0; rx_n = 0; npulse = 0; ncoll = 0;
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i == 0 || ones >= 6) ? 1'b0 : 1'($urandom_range(0, 1));
      ones = b ? ones + 1 : 0;
      sent[i] = b;
      send_bit(b);
    end
    trail = ones;
    wait_cells(ENDN + 3);
    for (int i = 0; i < nbits; i++)
      chk(rxq[i] == sent[i], "R6 loopback bit", int'(rxq[i]), int'(sent[i]));
    chk(rx_n == nbits + ENDN - trail, "R7 bits before unframe", rx_n, nbits + ENDN - trail);
    begin
      int zeros = 0;
      for (int i = 0; i < nbits; i++) if (!sent[i]) zeros++;
      chk(npulse == zeros, "R3 one pulse per zero only", npulse, zeros);
    end
    chk(ncoll == 0, "R8 no collide on own zeros", ncoll, 0);
    loop_en = 1'b0;

    // R4 R5: sub-minimum glitch while unframed gives nothing
    rx_n = 0;
    ext_pulse(ticks(15) - 1);
    wait_cells(3);
    chk(rx_n == 0, "R5 glitch does not frame", rx_n, 0);

    // R4: exact minimum pulse frames, glitch in next cell ignored
    rx_n = 0;
    ext_pulse(ticks(15));
    repeat (ticks(104) + 20) @(negedge clk);
    ext_pulse(ticks(15) - 1);
    wait_cells(ENDN + 3);
    chk(rxq[0] == 1'b0, "R4 minimum width is a zero", int'(rxq[0]), 0);
    chk(rxq[1] == 1'b1, "R4 short glitch is a one", int'(rxq[1]), 1);
    chk(rx_n == 1 + ENDN, "R7 trailing ones count", rx_n, 1 + ENDN);

    // R1: back-to-back cell spacing and ready
    nrise = 0;
    @(negedge clk);
    send_bit(1'b0);
    chk(tx_ready == 1'b0, "R1 ready low in cell", tx_ready, 0);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    wait_cells(2);
    chk(nrise == 3, "R3 pulses for 0,0,1,0", nrise, 3);
    chk(rise[1] - rise[0] == ticks(104), "R1 cell spacing", rise[1] - rise[0], ticks(104));
    chk(rise[2] - rise[1] == 2 * ticks(104), "R3 one cell quiet", rise[2] - rise[1], 2 * ticks(104));
    wait_cells(ENDN + 2);

    // R8: outside pulse while sending a 1
    ncoll = 0; loop_en = 1'b1;
    send_bit(1'b1);
    repeat (40) @(negedge clk);
    ext_pulse(ticks(35));
    wait_cells(1);
    chk(ncoll == 1, "R8 collide flagged", ncoll, 1);
    loop_en = 1'b0;
    wait_cells(ENDN + 2);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule